// File: doc/BRIEF.md
# I2C Target with Host-Stepped Handshake

This block is an I2C target that lets a local host decide every step of a bus transfer. It listens for its own 7-bit address. After the address byte, and after each received data byte, it raises a flag and holds SCL low. The bus stays stalled until the host answers through a four-register interface.

The host answer has two parts. The first is an acknowledge choice: drive ACK or NACK in the ninth clock. The second is a two-bit command code that releases the clock and picks the next step. What each code means depends on the direction bit captured from the address byte.

In the read direction, the block raises the data flag to ask for a byte. Writing the byte to the data register releases SCL and shifts the byte out MSB first. The controller's ACK brings a new request. Its NACK ends the sequence.

The SCL and SDA inputs pass through a synchronizer before any edge, START or STOP is detected. Both outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_cmd_target`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal TARGET_ADDR sets the address/stop flag (status bit 6) and latches bit 0 of that byte as the direction (status bit 4, 1 = target transmits). A byte with any other address sets no flag, does not hold SCL and leaves SDA released in the ninth clock. The block never drives SDA while it shifts in an address or data byte.
- R2: Whenever the data flag (status bit 7) or the address/stop flag is set, the block pulls SCL low, and status bit 5 reads 1. After reset, all status bits read 0 and neither line is driven.
- R3: Writing register 1 with bit 7 set clears the data flag. Writing register 1 with bit 6 set clears the address/stop flag.
- R4: Register 1 bits 1:0 take the command code. They always read 0. Code 00 and code 01 change nothing. A valid command (code 10 or 11 written while the block waits for one) clears both flags and releases SCL.
- R5: Code 11 after a write-direction address performs the acknowledge action in the ninth clock and then receives a byte. Acknowledge value 0 (register 1 bit 2) pulls SDA low; value 1 leaves SDA released. The received byte, assembled MSB first, reads from register 2, and the data flag is set at the end of the eighth clock.
- R6: When an acknowledge value and a command are written in the same register-1 write, the newly written acknowledge value is the one performed.
- R7: In the receive direction, code 10 performs the acknowledge action and then waits for a START. Bytes clocked before that START set no flag and are not acknowledged.
- R8: Code 11 after a read-direction address performs the acknowledge action and then sets the data flag. A write to register 2 while that flag is set clears the flag, releases SCL and shifts the byte out MSB first.
- R9: In the transmit direction, a controller ACK in the ninth clock sets the data flag again. A NACK leaves both flags clear and SDA released until the next START.
- R10: While waiting for transmit data, code 11 has no effect at all. Code 10 clears the flags, releases the bus and waits for a START without driving SDA.
- R11: With register 0 bit 0 set, a STOP sets the address/stop flag. With that bit clear, a STOP leaves the flags unchanged.
- R12: If a transmitted 1 bit is seen low at the rising edge of SCL, the block sets the address/stop flag, stops driving SDA and waits for a START.
- R13: The direction bit keeps its value through later data bytes and STOP conditions until the next matched address replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | input | 2 | Register select: 0 control, 1 status/command, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
The bench plays the controller on a wired-AND bus model and checks the ninth-clock SDA level after every stall. If the acknowledge were taken from the old register value instead of the value written with the command, the controller would read the wrong ACK/NACK. A command 11 during the transmit-data wait is checked to leave the stall in place; a design that treated it as valid would release SCL with no byte loaded. A bit collision is forced mid-byte, where a design without collision handling would keep driving and raise no flag. The bench also checks that a non-matching address, and bytes clocked after a "complete" command, are neither flagged nor acknowledged.

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h42,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [3:0] BYTE_END = 4'd8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AWAIT, ST_ACK, ST_RX, ST_RWAIT, ST_TXREQ, ST_TX, ST_TXACK
  } st_t;

  typedef enum logic [1:0] {NX_IDLE, NX_RX, NX_TXREQ} nx_t;

  st_t state;
  nx_t ack_next;
  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;
  logic [7:0] sh, tx_sh, rx_byte;
  logic [3:0] cnt;
  logic df, af, dir, ack_act, ack_bit, stop_en, nack;

  wire scl_s = scl_sync[SYNC_LEN-1];
  wire sda_s = sda_sync[SYNC_LEN-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det = scl_s & scl_d & ~sda_d & sda_s;

  wire wr_stat = reg_wr && reg_addr == REG_STAT;
  wire wr_data = reg_wr && reg_addr == REG_DATA;
  wire [1:0] cmd = reg_wdata[1:0];
  wire cmd_ok = wr_stat && cmd[1] &&
                (state == ST_AWAIT || state == ST_RWAIT ||
                 (state == ST_TXREQ && !cmd[0]));

  assign scl_oe = df | af;
  assign sda_oe = (state == ST_ACK && !ack_bit) || (state == ST_TX && !tx_sh[7]);

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {7'b0, stop_en};
      REG_STAT: reg_rdata = {df, af, scl_oe, dir, 1'b0, ack_act, 2'b00};
      REG_DATA: reg_rdata = rx_byte;
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      state    <= ST_IDLE;
      ack_next <= NX_IDLE;
      sh       <= '0;
      tx_sh    <= '0;
      rx_byte  <= '0;
      cnt      <= '0;
      df       <= 1'b0;
      af       <= 1'b0;
      dir      <= 1'b0;
      ack_act  <= 1'b0;
      ack_bit  <= 1'b1;
      stop_en  <= 1'b0;
      nack     <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      if (reg_wr && reg_addr == REG_CTRL) stop_en <= reg_wdata[0];
      if (wr_stat) ack_act <= reg_wdata[2];

      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        if (stop_en) af <= 1'b1;
      end else if (cmd_ok) begin
        if (state == ST_TXREQ || (dir && !cmd[0])) begin
          state <= ST_IDLE;
        end else begin
          state    <= ST_ACK;
          ack_bit  <= reg_wdata[2];
          ack_next <= !cmd[0] ? NX_IDLE : (dir ? NX_TXREQ : NX_RX);
        end
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt != BYTE_END) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BYTE_END) begin
              cnt <= '0;
              if (state == ST_RX) begin
                rx_byte <= sh;
                df      <= 1'b1;
                state   <= ST_RWAIT;
              end else if (sh[7:1] == TARGET_ADDR) begin
                af    <= 1'b1;
                dir   <= sh[0];
                state <= ST_AWAIT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              case (ack_next)
                NX_RX: begin
                  state <= ST_RX;
                  cnt   <= '0;
                end
                NX_TXREQ: begin
                  state <= ST_TXREQ;
                  df    <= 1'b1;
                end
                default: state <= ST_IDLE;
              endcase
            end
          end
          ST_TXREQ: begin
            if (wr_data) begin
              tx_sh <= reg_wdata;
              df    <= 1'b0;
              cnt   <= '0;
              state <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise && tx_sh[7] && !sda_s) begin
              af    <= 1'b1;
              state <= ST_IDLE;
            end else if (scl_fall) begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              cnt   <= cnt + 4'd1;
              if (cnt == BYTE_END - 4'd1) state <= ST_TXACK;
            end
          end
          ST_TXACK: begin
            if (scl_rise) nack <= sda_s;
            if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                df    <= 1'b1;
                state <= ST_TXREQ;
              end
            end
          end
          default: ;
        endcase
      end

      if (cmd_ok || (wr_stat && reg_wdata[7])) df <= 1'b0;
      if (cmd_ok || (wr_stat && reg_wdata[6])) af <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       df,
  input logic       af,
  input logic [3:0] st
);
  localparam logic [3:0] S_ADDR = 4'd1;
  localparam logic [3:0] S_AWAIT = 4'd2;
  localparam logic [3:0] S_RX = 4'd4;

  assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[1:0] == 2'b00));

  assert_cmd_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[1] && st == S_AWAIT) |=> (!af && !df));

  assert_clear_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[7]) |=> !df);

  assert_clear_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[6]) |=> !af);

  assert_quiet_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR || st == S_RX) |-> !sda_oe);

  assert_drive_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_cmd_target i2c_cmd_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
  .scl_s(scl_s), .df(df), .af(af), .st(state)
);

// File: tb/i2c_cmd_target_test.sv
`timescale 1ns/1ps
module i2c_cmd_target_test;
  localparam logic [6:0] ADDR = 7'h42;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  wire scl_line = !(m_scl_low || scl_oe);
  wire sda_line = !(m_sda_low || sda_oe);

  int checks = 0, fails = 0;
  bit done = 0;
  bit cmp_en = 0;
  logic exp_df = 0, exp_af = 0, exp_dir = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  i2c_cmd_target #(.TARGET_ADDR(ADDR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // reference model of flags, hold and direction, compared every clock
  always @(negedge clk) begin
    if (cmp_en && rst_n && !reg_wr && reg_addr == 2'd1) begin
      checks++;
      if (reg_rdata[7:4] !== {exp_df, exp_af, exp_df | exp_af, exp_dir} ||
          scl_oe !== (exp_df | exp_af)) begin
        fails++;
        $display("FAIL %s model status=%b scl_oe=%b expected status=%b scl_oe=%b",
                 cur_req, reg_rdata[7:4], scl_oe,
                 {exp_df, exp_af, exp_df | exp_af, exp_dir}, exp_df | exp_af);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input logic df, input logic af, input logic dir, input string req);
    cyc(6);
    exp_df = df; exp_af = af; exp_dir = dir; cur_req = req;
    cmp_en = 1;
    cyc(4);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    cmp_en = 0;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_addr = 2'd1;
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda_low = !b;
    cyc(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    cyc(H / 2);
    r = sda_line;
    cyc(H / 2);
    m_scl_low = 1'b1;
    cyc(H);
  endtask

  task automatic bus_start();
    cmp_en = 0;
    m_sda_low = 1'b1; cyc(H);
    m_scl_low = 1'b1; cyc(H);
  endtask

  task automatic bus_stop();
    cmp_en = 0;
    m_sda_low = 1'b1; cyc(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    cyc(H);
    m_sda_low = 1'b0; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic r;
    cmp_en = 0;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic r;
    cmp_en = 0;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      v = {v[6:0], r};
    end
  endtask

  task automatic ninth(input logic b, output logic r);
    cmp_en = 0;
    clk_bit(b, r);
  endtask

  initial begin
    logic r;
    logic [7:0] v;
    cyc(5);
    check("R2", reg_rdata, 8'h00);
    check("R2", {6'b0, scl_oe, sda_oe}, 8'h00);
    rst_n = 1'b1;
    settle(0, 0, 0, "R2");

    // R1: other address is ignored; R11: STOP with enable clear sets nothing
    bus_start();
    send_byte({7'h10, 1'b0});
    settle(0, 0, 0, "R1");
    ninth(1'b1, r);
    check("R1", {7'b0, r}, 8'h01);
    bus_stop();
    settle(0, 0, 0, "R11");

    // write direction: R1, R2, R4, R5, R6, R7
    bus_start();
    send_byte({ADDR, 1'b0});
    settle(0, 1, 0, "R1");
    check("R2", {7'b0, scl_line}, 8'h00);
    check("R1", {7'b0, sda_oe}, 8'h00);
    host_wr(2'd1, 8'h00);
    settle(0, 1, 0, "R4");
    host_wr(2'd1, 8'h01);
    settle(0, 1, 0, "R4");
    check("R4", {6'b0, reg_rdata[1:0]}, 8'h00);
    host_wr(2'd1, 8'h03);
    settle(0, 0, 0, "R5");
    ninth(1'b1, r);
    check("R5", {7'b0, r}, 8'h00);
    send_byte(8'hC3);
    settle(1, 0, 0, "R5");
    host_rd(2'd2, v);
    check("R5", v, 8'hC3);
    host_wr(2'd1, 8'h07);
    settle(0, 0, 0, "R6");
    ninth(1'b1, r);
    check("R6", {7'b0, r}, 8'h01);
    send_byte(8'h5A);
    settle(1, 0, 0, "R6");
    host_rd(2'd2, v);
    check("R6", v, 8'h5A);
    host_wr(2'd1, 8'h02);
    settle(0, 0, 0, "R7");
    ninth(1'b1, r);
    check("R7", {7'b0, r}, 8'h00);
    send_byte(8'h96);
    settle(0, 0, 0, "R7");
    ninth(1'b1, r);
    check("R7", {7'b0, r}, 8'h01);
    bus_stop();
    settle(0, 0, 0, "R7");

    // read direction: R8, R9, R10, R13
    bus_start();
    send_byte({ADDR, 1'b1});
    settle(0, 1, 1, "R1");
    host_wr(2'd1, 8'h03);
    settle(0, 0, 1, "R8");
    ninth(1'b1, r);
    check("R8", {7'b0, r}, 8'h00);
    settle(1, 0, 1, "R8");
    host_wr(2'd2, 8'hA5);
    settle(0, 0, 1, "R8");
    recv_byte(v);
    check("R8", v, 8'hA5);
    ninth(1'b0, r);
    settle(1, 0, 1, "R9");
    host_wr(2'd1, 8'h03);
    settle(1, 0, 1, "R10");
    host_wr(2'd2, 8'h3C);
    recv_byte(v);
    check("R8", v, 8'h3C);
    ninth(1'b1, r);
    settle(0, 0, 1, "R9");
    recv_byte(v);
    check("R9", v, 8'hFF);
    bus_stop();
    settle(0, 0, 1, "R13");

    bus_start();
    send_byte({ADDR, 1'b1});
    settle(0, 1, 1, "R1");
    host_wr(2'd1, 8'h03);
    ninth(1'b1, r);
    settle(1, 0, 1, "R8");
    host_wr(2'd1, 8'h02);
    settle(0, 0, 1, "R10");
    recv_byte(v);
    check("R10", v, 8'hFF);
    ninth(1'b1, r);
    bus_stop();
    settle(0, 0, 1, "R13");

    // R3 and R13: flag clears, direction replaced on new address
    bus_start();
    send_byte({ADDR, 1'b0});
    settle(0, 1, 0, "R13");
    host_wr(2'd1, 8'h03);
    ninth(1'b1, r);
    send_byte(8'h11);
    settle(1, 0, 0, "R3");
    host_wr(2'd1, 8'h80);
    settle(0, 0, 0, "R3");
    ninth(1'b1, r);
    check("R3", {7'b0, r}, 8'h01);
    bus_stop();
    bus_start();
    send_byte({ADDR, 1'b0});
    settle(0, 1, 0, "R3");
    host_wr(2'd1, 8'h40);
    settle(0, 0, 0, "R3");
    ninth(1'b1, r);
    bus_stop();

    // R11: STOP with enable set
    host_wr(2'd0, 8'h01);
    host_rd(2'd0, v);
    check("R11", v, 8'h01);
    bus_start();
    send_byte({ADDR, 1'b0});
    host_wr(2'd1, 8'h02);
    ninth(1'b1, r);
    check("R11", {7'b0, r}, 8'h00);
    bus_stop();
    settle(0, 1, 0, "R11");
    host_wr(2'd1, 8'h40);
    settle(0, 0, 0, "R11");
    host_wr(2'd0, 8'h00);

    // R12: collision on a transmitted 1
    bus_start();
    send_byte({ADDR, 1'b1});
    host_wr(2'd1, 8'h03);
    ninth(1'b1, r);
    settle(1, 0, 1, "R8");
    host_wr(2'd2, 8'h80);
    cmp_en = 0;
    clk_bit(1'b0, r);
    settle(0, 1, 1, "R12");
    check("R12", {7'b0, sda_oe}, 8'h00);
    host_wr(2'd1, 8'h40);
    settle(0, 0, 1, "R12");
    bus_stop();
    settle(0, 0, 1, "R12");

    finish_run();
  end
endmodule